// File: doc/BRIEF.md
# CAN Error Flag Capture Unit

This block sits between a CAN protocol engine and the CPU register port. It turns single-cycle event pulses from the engine into sticky flags. There are two groups of flags. The first group is seven protocol error codes: stuff, form, ACK, CRC, recessive bit, dominant bit and ACK delimiter. The second group is eight controller events: bus error, error warning, error passive, bus-off entry, bus-off recovery, receive overrun, overload frame sent and bus lock. Software clears a flag by writing 0 to its bit. Writing 1 to a bit leaves that flag as it was.

A mode bit in the error-code register selects how the code flags behave. In one setting the codes pile up, so several can be set at once. In the other setting only the codes of the latest event are kept. Each controller-event flag has its own enable bit. The OR of the enabled flags drives a summary error status bit. A separate interrupt enable bit gates that summary onto the error interrupt output. The current transmit and receive error counts from the engine can also be read through the same port.

Register map on `addr_i`:

| Address | Register |
|---|---|
| 0 | error-code register |
| 1 | event-flag register |
| 2 | event-enable register |
| 3 | interrupt status |
| 4 | interrupt enable |
| 5 | transmit error count |
| 6 | receive error count |
| 7 | reads zero |

Reads are combinational.

Top module: `can_err_flags`

## Requirements
- R1: After reset, every flag, the mode bit, all event enables and the interrupt enable are 0. `err_irq_o` is low and addresses 0 to 4 and 7 read 0.
- R2: A pulse on `code_evt_i` sets the matching error-code flag on the next clock edge. The bit positions are:
  - bit 0: stuff error
  - bit 1: form error
  - bit 2: ACK error
  - bit 3: CRC error
  - bit 4: recessive bit error
  - bit 5: dominant bit error
  - bit 6: ACK delimiter error
- R3: With the mode bit (error-code bit 7) at 1, new code events are ORed into the flags already set.
- R4: With the mode bit at 0, any code event replaces all code flags with the flags of that event. Codes that pulse in the same cycle are all kept.
- R5: Writing 0 to a flag bit of the error-code or event-flag register clears that flag. Writing 1 leaves it unchanged.
- R6: If an event pulse and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R7: A pulse on `fac_evt_i` sets the matching event flag on the next edge. The bit positions are:
  - bit 0: bus error
  - bit 1: warning
  - bit 2: passive
  - bit 3: bus-off entry
  - bit 4: bus-off recovery
  - bit 5: overrun
  - bit 6: overload
  - bit 7: bus lock
- R8: The event-enable register (address 2) is a plain read/write register with the same bit layout as the event-flag register.
- R9: Interrupt status bit 5 is 1 whenever some event flag and its enable bit are both 1, and 0 once none are. The other status bits read 0, and writes to the status address have no effect.
- R10: `err_irq_o` equals status bit 5 ANDed with interrupt-enable bit 5. Only bit 5 of the interrupt-enable register is stored; its other bits read 0.
- R11: Addresses 5 and 6 return the current `tec_i` and `rec_i` values.
- R12: The mode bit is plain read/write. Writes to the count addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| code_evt_i | input | 7 | Error-code event pulses, laid out as in R2 |
| fac_evt_i | input | 8 | Controller event pulses, laid out as in R7 |
| tec_i | input | 8 | Transmit error count from the engine |
| rec_i | input | 8 | Receive error count from the engine |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| err_irq_o | output | 1 | Error interrupt |

## Verification
The bench targets the following corner cases:

- **Overwrite mode replacing flags.** It drives code pulses in overwrite mode and checks that the old flags are dropped. A design that ignored the mode bit would show stale codes next to the new one.
- **Simultaneous codes in overwrite mode.** It pulses two codes in the same cycle with the mode bit at 0. A design that kept only one of them would lose a flag.
- **Event against clearing write.** It lands an event and a zero write on the same flag in the same cycle. A design where the write won would lose the event.
- **Summary status tracking.** It checks the summary bit against the enable mask and the interrupt enable, including when a clearing write removes the last enabled flag. A summary that was sticky, or that ignored the enables, would keep the interrupt raised.
- **Writes that must be ignored.** It writes to the status and count addresses. A design that stored those writes would corrupt what is read back.

// File: rtl/can_err_pkg.sv
package can_err_pkg;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 3;
  localparam int unsigned N_CODE   = 7;
  localparam int unsigned N_FAC    = 8;
  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned ERS_BIT  = 5;

  typedef enum logic [AW-1:0] {
    A_CODE = 3'd0,
    A_FAC  = 3'd1,
    A_FEN  = 3'd2,
    A_STAT = 3'd3,
    A_IEN  = 3'd4,
    A_TEC  = 3'd5,
    A_REC  = 3'd6,
    A_NONE = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/can_err_flag_cell.sv
// One sticky flag: set beats every form of clear.
module can_err_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic kill_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q_o <= 1'b0;
    else if (set_i)           q_o <= 1'b1;
    else if (clr_i || kill_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/can_err_code_reg.sv
module can_err_code_reg
  import can_err_pkg::*;
#(
  parameter int unsigned N = N_CODE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  flags_o,
  output logic          mode_o
);
  logic any_evt;
  logic kill;

  assign any_evt = |evt_i;
  // overwrite mode: any new event wipes flags not pulsed this cycle
  assign kill    = any_evt & ~mode_o;

  for (genvar i = 0; i < N; i++) begin : g_cell
    can_err_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[i]),
      .clr_i  (we_i & ~wdata_i[i]),
      .kill_i (kill),
      .q_o    (flags_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mode_o <= 1'b0;
    else if (we_i) mode_o <= wdata_i[MODE_BIT];
  end
endmodule

// File: rtl/can_err_factor_reg.sv
module can_err_factor_reg
  import can_err_pkg::*;
#(
  parameter int unsigned N = N_FAC
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         flag_we_i,
  input  logic         en_we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         pend_o
);
  for (genvar i = 0; i < N; i++) begin : g_cell
    can_err_flag_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt_i[i]),
      .clr_i  (flag_we_i & ~wdata_i[i]),
      .kill_i (1'b0),
      .q_o    (flags_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (en_we_i) en_o <= wdata_i;
  end

  assign pend_o = |(flags_o & en_o);
endmodule

// File: rtl/can_err_rd_mux.sv
module can_err_rd_mux
  import can_err_pkg::*;
(
  input  logic [AW-1:0]     addr_i,
  input  logic [N_CODE-1:0] code_i,
  input  logic              mode_i,
  input  logic [N_FAC-1:0]  fac_i,
  input  logic [N_FAC-1:0]  fen_i,
  input  logic              pend_i,
  input  logic              ien_i,
  input  logic [DW-1:0]     tec_i,
  input  logic [DW-1:0]     rec_i,
  output logic [DW-1:0]     rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      A_CODE: begin
        rdata_o[N_CODE-1:0] = code_i;
        rdata_o[MODE_BIT]   = mode_i;
      end
      A_FAC:  rdata_o = fac_i;
      A_FEN:  rdata_o = fen_i;
      A_STAT: rdata_o[ERS_BIT] = pend_i;
      A_IEN:  rdata_o[ERS_BIT] = ien_i;
      A_TEC:  rdata_o = tec_i;
      A_REC:  rdata_o = rec_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/can_err_flags.sv
module can_err_flags
  import can_err_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CODE-1:0] code_evt_i,
  input  logic [N_FAC-1:0]  fac_evt_i,
  input  logic [DW-1:0]     tec_i,
  input  logic [DW-1:0]     rec_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_irq_o
);
  logic [N_CODE-1:0] code_flags;
  logic              code_mode;
  logic [N_FAC-1:0]  fac_flags;
  logic [N_FAC-1:0]  fac_en;
  logic              fac_pend;
  logic              ien_q;

  logic we_code, we_fac, we_fen, we_ien;

  assign we_code = wr_en_i && (addr_i == A_CODE);
  assign we_fac  = wr_en_i && (addr_i == A_FAC);
  assign we_fen  = wr_en_i && (addr_i == A_FEN);
  assign we_ien  = wr_en_i && (addr_i == A_IEN);

  can_err_code_reg #(.N(N_CODE)) u_code (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (code_evt_i),
    .we_i    (we_code),
    .wdata_i (wdata_i),
    .flags_o (code_flags),
    .mode_o  (code_mode)
  );

  can_err_factor_reg #(.N(N_FAC)) u_fac (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (fac_evt_i),
    .flag_we_i (we_fac),
    .en_we_i   (we_fen),
    .wdata_i   (wdata_i[N_FAC-1:0]),
    .flags_o   (fac_flags),
    .en_o      (fac_en),
    .pend_o    (fac_pend)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ien_q <= 1'b0;
    else if (we_ien) ien_q <= wdata_i[ERS_BIT];
  end

  assign err_irq_o = fac_pend & ien_q;

  can_err_rd_mux u_rd (
    .addr_i  (addr_i),
    .code_i  (code_flags),
    .mode_i  (code_mode),
    .fac_i   (fac_flags),
    .fen_i   (fac_en),
    .pend_i  (fac_pend),
    .ien_i   (ien_q),
    .tec_i   (tec_i),
    .rec_i   (rec_i),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/can_err_flags_chk.sv
module can_err_flags_chk
  import can_err_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_CODE-1:0] code_evt_i,
  input logic [N_FAC-1:0]  fac_evt_i,
  input logic              wr_en_i,
  input logic [AW-1:0]     addr_i,
  input logic              err_irq_o,
  input logic [N_CODE-1:0] code_flags,
  input logic              code_mode,
  input logic [N_FAC-1:0]  fac_flags,
  input logic [N_FAC-1:0]  fac_en,
  input logic              ien_q
);
  logic code_wr;
  assign code_wr = wr_en_i && (addr_i == A_CODE);

  // R7, R6: every pulsed event flag is set after the edge, whatever the write did
  a_r7_fac_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fac_evt_i) |=> ((fac_flags & $past(fac_evt_i)) == $past(fac_evt_i)));

  // R5: an event flag never rises without its pulse
  a_r5_no_spurious_fac: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fac_flags & ~$past(fac_flags) & ~$past(fac_evt_i)) == '0));

  // R4: overwrite mode keeps only the latest codes
  a_r4_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!code_mode && (|code_evt_i)) |=> (code_flags == $past(code_evt_i)));

  // R3: accumulate mode without a write is a pure OR
  a_r3_accumulate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_mode && !code_wr) |=> (code_flags == $past(code_flags | code_evt_i)));

  // R10: interrupt only with an enabled pending flag
  a_r10_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o |-> (ien_q && ((fac_flags & fac_en) != '0)));
endmodule

bind can_err_flags can_err_flags_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .code_evt_i (code_evt_i),
  .fac_evt_i  (fac_evt_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .err_irq_o  (err_irq_o),
  .code_flags (code_flags),
  .code_mode  (code_mode),
  .fac_flags  (fac_flags),
  .fac_en     (fac_en),
  .ien_q      (ien_q)
);

// File: tb/can_err_flags_tb_top.sv
module can_err_flags_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] code_evt_i = '0;
  logic [7:0] fac_evt_i = '0;
  logic [7:0] tec_i = 8'h12;
  logic [7:0] rec_i = 8'h34;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       err_irq_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  can_err_flags dut_i (.*);

  typedef struct {
    logic [2:0] a;
    logic [7:0] d;
    logic       irq;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  logic  rd_vld = 1'b0;
  logic  done = 1'b0;

  // monitor: samples mid-low-phase of each read cycle
  initial forever begin
    @(negedge clk_i);
    #1;
    if (rd_vld && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (rdata_o !== it.d || err_irq_o !== it.irq) begin
        n_fail++;
        $display("FAIL %s addr=%0d rdata=%02h exp=%02h irq=%b exp_irq=%b",
                 it.tag, it.a, rdata_o, it.d, err_irq_o, it.irq);
      end
    end
  end

  task automatic chk(input logic [2:0] a, input logic [7:0] d, input logic irq, input string tag);
    item_t it;
    @(negedge clk_i);
    it.a = a; it.d = d; it.irq = irq; it.tag = tag;
    q.push_back(it);
    addr_i = a;
    rd_vld = 1'b1;
    @(negedge clk_i);
    rd_vld = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] c, input logic [7:0] f);
    @(negedge clk_i);
    code_evt_i = c; fac_evt_i = f;
    @(negedge clk_i);
    code_evt_i = '0; fac_evt_i = '0;
  endtask

  task automatic pulse_wr(input logic [6:0] c, input logic [7:0] f,
                          input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    code_evt_i = c; fac_evt_i = f;
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    code_evt_i = '0; fac_evt_i = '0; wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state, R11 counts
    for (int a = 0; a < 8; a++) begin
      logic [7:0] e;
      e = (a == 5) ? 8'h12 : (a == 6) ? 8'h34 : 8'h00;
      chk(a[2:0], e, 1'b0, (a == 5 || a == 6) ? "R11 count" : "R1 reset");
    end
    // R2 stuff error -> bit 0
    pulse(7'h01, 8'h00);
    chk(3'd0, 8'h01, 1'b0, "R2 stuff bit0");
    // R4 overwrite: CRC replaces stuff
    pulse(7'h08, 8'h00);
    chk(3'd0, 8'h08, 1'b0, "R4 overwrite crc");
    pulse(7'h30, 8'h00);
    chk(3'd0, 8'h30, 1'b0, "R4 simultaneous keep both");
    // R12 mode bit set, R5 zero write clears flags
    wr(3'd0, 8'h80);
    chk(3'd0, 8'h80, 1'b0, "R12 mode set R5 clear");
    // R3 accumulate
    pulse(7'h01, 8'h00);
    pulse(7'h40, 8'h00);
    chk(3'd0, 8'hC1, 1'b0, "R3 accumulate");
    wr(3'd0, 8'hFE);
    chk(3'd0, 8'hC0, 1'b0, "R5 clear bit0");
    wr(3'd0, 8'hFF);
    chk(3'd0, 8'hC0, 1'b0, "R5 write one no effect");
    // R6 event wins against clearing write
    pulse_wr(7'h02, 8'h00, 3'd0, 8'h80);
    chk(3'd0, 8'h82, 1'b0, "R6 code event wins");
    // R7 factor flags
    pulse(7'h00, 8'h09);
    chk(3'd1, 8'h09, 1'b0, "R7 factor set");
    chk(3'd3, 8'h00, 1'b0, "R9 no enable no status");
    wr(3'd2, 8'h08);
    chk(3'd2, 8'h08, 1'b0, "R8 enable rw");
    chk(3'd3, 8'h20, 1'b0, "R9 status set");
    wr(3'd4, 8'hFF);
    chk(3'd4, 8'h20, 1'b1, "R10 ien only bit5");
    wr(3'd1, 8'hF7);
    chk(3'd1, 8'h01, 1'b0, "R5 factor clear");
    chk(3'd3, 8'h00, 1'b0, "R9 status drops");
    pulse(7'h00, 8'h08);
    wr(3'd3, 8'h00);
    chk(3'd3, 8'h20, 1'b1, "R9 status write ignored");
    wr(3'd4, 8'h00);
    chk(3'd3, 8'h20, 1'b0, "R10 irq gated off");
    pulse_wr(7'h00, 8'h80, 3'd1, 8'h00);
    chk(3'd1, 8'h80, 1'b0, "R6 factor event wins");
    wr(3'd5, 8'hEE);
    chk(3'd5, 8'h12, 1'b0, "R12 count write ignored");
    @(negedge clk_i); tec_i = 8'hA5; rec_i = 8'h5A;
    chk(3'd5, 8'hA5, 1'b0, "R11 tec follows");
    chk(3'd6, 8'h5A, 1'b0, "R11 rec follows");
    wr(3'd0, 8'h00);
    pulse(7'h04, 8'h00);
    pulse(7'h10, 8'h00);
    chk(3'd0, 8'h10, 1'b0, "R4 mode cleared overwrite");
    done = 1'b1;
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule